// File: doc/BRIEF.md
# Phase-Synchronised Up-Down PWM Timebase

This block is one channel of a carrier generator. Its counter climbs from zero to an active period and falls back to zero. Two compare values turn that triangle into two PWM outputs. Each output goes high when its compare value is crossed on the rising slope and goes low when it is crossed on the falling slope.

Several channels can be chained so their carriers sit at fixed offsets. A channel with phase loading disabled acts as the chain master. A channel with phase loading enabled reloads its counter from a phase value whenever a sync pulse arrives. The same reload also forces a chosen counting direction. Because of that, one phase magnitude gives two different offsets:

- Half the period with a downward direction places a follower a quarter-turn behind the master.
- Half the period with an upward direction places it three quarters behind.
- A phase equal to the period gives a half-turn offset.

Each channel's sync output either repeats its sync input or pulses at its own counter zero, so the chain can be extended. A zero-count strobe is also provided for interrupt use.

Top module: `pwm_phase_timebase`

## Requirements
- R1: While reset is asserted and straight after it, `cnt_o` is 0, `dir_up_o` is 1, both PWM outputs are 0, and the active and shadow periods are 0. With an active period of 0 the counter holds at 0.
- R2: With no phase load and an active period P > 0, the counter counts in single steps. It rises from 0 to P, spends exactly one cycle at P, falls to 0 and spends exactly one cycle at 0. `dir_up_o` is 1 on the rising slope and at P, and 0 on the falling slope and at 0.
- R3: A write (`prd_wr` high) stores `prd_val` only in a shadow register. The shadow becomes the active period on the clock edge that ends a cycle in which `cnt_o` is 0. Until then the counter keeps turning at the old period.
- R4: When `phs_en` is 1 and `sync_in` is high at a rising clock edge, the next cycle shows `cnt_o` = `phs_val` and `dir_up_o` = `phs_dir` (1 = up, 0 = down). Counting continues from there. A loaded value at or above the period while counting up turns downward on the next step.
- R5: When `phs_en` is 0, `sync_in` has no effect on the counter or on its direction.
- R6: When `sync_sel` is 1, `sync_out` is high exactly in the cycles where `cnt_o` is 0. When `sync_sel` is 0, `sync_out` follows `sync_in` in the same cycle.
- R7: If `cnt_o` equals a nonzero `cmp_a` that is no greater than the active period, then `pwm_a` takes the value of `dir_up_o` in the following cycle: set while counting up, cleared while counting down.
- R8: `pwm_b` follows the rule of R7 using `cmp_b`.
- R9: A compare value of 0, or one greater than the active period, never matches. The output then keeps its level.
- R10: `zero_irq` is high exactly in the cycles where `cnt_o` is 0. With P > 0 and no phase load, each such strobe lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| prd_wr | input | 1 | Write strobe for the shadow period |
| prd_val | input | CNT_W | Period value to write |
| phs_en | input | 1 | Enables the phase reload on sync |
| phs_dir | input | 1 | Direction forced on reload, 1 = up |
| phs_val | input | CNT_W | Counter value loaded on sync |
| sync_sel | input | 1 | Sync output source: 1 = own zero, 0 = pass-through |
| cmp_a | input | CNT_W | Compare value for output A |
| cmp_b | input | CNT_W | Compare value for output B |
| sync_in | input | 1 | Sync pulse from the previous channel |
| cnt_o | output | CNT_W | Counter value |
| dir_up_o | output | 1 | Counting direction, 1 = up |
| pwm_a | output | 1 | PWM output A |
| pwm_b | output | 1 | PWM output B |
| sync_out | output | 1 | Sync pulse to the next channel |
| zero_irq | output | 1 | Counter-at-zero strobe |

## Verification
The bench builds the channel with CNT_W = 6, so random periods, phase values and compare values all fit in 0 to 63. With these widths the bench regularly reaches compare values above the period, phase values above the period, and period writes that land mid-slope. The narrow counter means each random run covers many complete triangles and many sync reloads in both forced directions. Directed cases cover the reset state, a reload downward to half the period, master mode ignoring sync, and a compare value of zero.

// File: rtl/pwmtb_pkg.sv
package pwmtb_pkg;
  typedef enum logic {
    CNT_DOWN = 1'b0,
    CNT_UP   = 1'b1
  } cnt_dir_e;
endpackage

// File: rtl/pwmtb_counter.sv
module pwmtb_counter
  import pwmtb_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             prd_wr,
  input  logic [CNT_W-1:0] prd_val,
  input  logic             phs_load,
  input  logic [CNT_W-1:0] phs_val,
  input  logic             phs_dir,
  output logic [CNT_W-1:0] cnt_q,
  output cnt_dir_e         dir_q,
  output logic [CNT_W-1:0] prd_q
);
  localparam logic [CNT_W-1:0] ZERO = '0;
  localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] shd_q;
  logic [CNT_W-1:0] cnt_d;
  cnt_dir_e         dir_d;
  logic             shd_en;
  logic             prd_en;
  logic             at_zero;

  assign at_zero = (cnt_q == ZERO);
  assign shd_en  = prd_wr;
  assign prd_en  = at_zero;

  // next-state: reload, or step with a one-count turn at each end
  always_comb begin
    cnt_d = cnt_q;
    dir_d = dir_q;
    if (phs_load) begin
      cnt_d = phs_val;
      dir_d = cnt_dir_e'(phs_dir);
    end else if (dir_q == CNT_UP) begin
      if (cnt_q >= prd_q) begin
        if (prd_q == ZERO) begin
          cnt_d = ZERO;
          dir_d = CNT_UP;
        end else begin
          cnt_d = cnt_q - ONE;
          dir_d = CNT_DOWN;
        end
      end else begin
        cnt_d = cnt_q + ONE;
        dir_d = CNT_UP;
      end
    end else begin
      if (at_zero) begin
        cnt_d = (prd_q == ZERO) ? ZERO : ONE;
        dir_d = CNT_UP;
      end else begin
        cnt_d = cnt_q - ONE;
        dir_d = CNT_DOWN;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= ZERO;
      dir_q <= CNT_UP;
    end else begin
      cnt_q <= cnt_d;
      dir_q <= dir_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shd_q <= ZERO;
    end else if (shd_en) begin
      shd_q <= prd_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prd_q <= ZERO;
    end else if (prd_en) begin
      prd_q <= shd_q;
    end
  end

  assert_count_up_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!phs_load && dir_q == CNT_UP && cnt_q < prd_q) |=> (cnt_q == $past(cnt_q) + ONE));

  assert_turn_top_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!phs_load && dir_q == CNT_UP && cnt_q == prd_q && prd_q != ZERO)
      |=> (dir_q == CNT_DOWN && cnt_q == $past(cnt_q) - ONE));

  assert_turn_bottom_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!phs_load && dir_q == CNT_DOWN && cnt_q == ZERO && prd_q != ZERO)
      |=> (dir_q == CNT_UP && cnt_q == ONE));

  assert_phase_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    phs_load |=> (cnt_q == $past(phs_val) && dir_q == $past(phs_dir)));

  assert_shadow_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != ZERO) |=> $stable(prd_q));
endmodule

// File: rtl/pwmtb_action.sv
module pwmtb_action #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt,
  input  logic             dir_up,
  input  logic [CNT_W-1:0] prd,
  input  logic [CNT_W-1:0] cmp,
  output logic             out_q
);
  localparam logic [CNT_W-1:0] ZERO = '0;

  logic hit;
  logic out_d;

  assign hit   = (cmp != ZERO) && (cmp <= prd) && (cnt == cmp);
  assign out_d = dir_up;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= 1'b0;
    end else if (hit) begin
      out_q <= out_d;
    end
  end

  // shared by output A (R7) and output B (R8)
  assert_set_rising_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == cmp && cmp != ZERO && cmp <= prd && dir_up) |=> out_q);

  assert_clear_falling_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == cmp && cmp != ZERO && cmp <= prd && !dir_up) |=> !out_q);

  assert_zero_cmp_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp == ZERO) |=> $stable(out_q));

  assert_high_cmp_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp > prd) |=> $stable(out_q));
endmodule

// File: rtl/pwm_phase_timebase.sv
module pwm_phase_timebase
  import pwmtb_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             prd_wr,
  input  logic [CNT_W-1:0] prd_val,
  input  logic             phs_en,
  input  logic             phs_dir,
  input  logic [CNT_W-1:0] phs_val,
  input  logic             sync_sel,
  input  logic [CNT_W-1:0] cmp_a,
  input  logic [CNT_W-1:0] cmp_b,
  input  logic             sync_in,
  output logic [CNT_W-1:0] cnt_o,
  output logic             dir_up_o,
  output logic             pwm_a,
  output logic             pwm_b,
  output logic             sync_out,
  output logic             zero_irq
);
  localparam int NUM_CMP = 2;
  localparam logic [CNT_W-1:0] ZERO = '0;

  logic [CNT_W-1:0] cnt_q;
  cnt_dir_e         dir_q;
  logic [CNT_W-1:0] prd_q;
  logic             phs_load;
  logic [CNT_W-1:0] cmp_vec [NUM_CMP];
  logic [NUM_CMP-1:0] pwm_vec;

  assign phs_load = sync_in & phs_en;

  pwmtb_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .prd_wr   (prd_wr),
    .prd_val  (prd_val),
    .phs_load (phs_load),
    .phs_val  (phs_val),
    .phs_dir  (phs_dir),
    .cnt_q    (cnt_q),
    .dir_q    (dir_q),
    .prd_q    (prd_q)
  );

  assign cmp_vec[0] = cmp_a;
  assign cmp_vec[1] = cmp_b;

  for (genvar g = 0; g < NUM_CMP; g++) begin : g_act
    pwmtb_action #(.CNT_W(CNT_W)) u_act (
      .clk    (clk),
      .rst_n  (rst_n),
      .cnt    (cnt_q),
      .dir_up (dir_q == CNT_UP),
      .prd    (prd_q),
      .cmp    (cmp_vec[g]),
      .out_q  (pwm_vec[g])
    );
  end

  assign cnt_o    = cnt_q;
  assign dir_up_o = (dir_q == CNT_UP);
  assign pwm_a    = pwm_vec[0];
  assign pwm_b    = pwm_vec[1];
  assign zero_irq = (cnt_q == ZERO);
  assign sync_out = sync_sel ? zero_irq : sync_in;

  assert_irq_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_irq && !phs_load && prd_q != ZERO) |=> !zero_irq);

  assert_master_ignores_sync_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_in && !phs_en && dir_q == CNT_UP && cnt_q < prd_q) |=> (cnt_o == $past(cnt_o) + 1'b1));
endmodule

// File: tb/tb_pwm_phase_timebase.sv
module tb_pwm_phase_timebase;
  localparam int W = 6;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic         rst_n;
  logic         prd_wr;
  logic [W-1:0] prd_val;
  logic         phs_en;
  logic         phs_dir;
  logic [W-1:0] phs_val;
  logic         sync_sel;
  logic [W-1:0] cmp_a;
  logic [W-1:0] cmp_b;
  logic         sync_in;
  logic [W-1:0] cnt_o;
  logic         dir_up_o;
  logic         pwm_a;
  logic         pwm_b;
  logic         sync_out;
  logic         zero_irq;

  pwm_phase_timebase #(.CNT_W(W)) dut (
    .clk(clk), .rst_n(rst_n), .prd_wr(prd_wr), .prd_val(prd_val),
    .phs_en(phs_en), .phs_dir(phs_dir), .phs_val(phs_val),
    .sync_sel(sync_sel), .cmp_a(cmp_a), .cmp_b(cmp_b), .sync_in(sync_in),
    .cnt_o(cnt_o), .dir_up_o(dir_up_o), .pwm_a(pwm_a), .pwm_b(pwm_b),
    .sync_out(sync_out), .zero_irq(zero_irq)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  // reference state, derived from the requirements
  int m_cnt, m_up, m_prd, m_shd, m_a, m_b;

  task automatic chk(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic int act_rule(int cur, int cmp, int prd, int cnt, int up);
    if (cmp != 0 && cmp <= prd && cnt == cmp) return up;
    return cur;
  endfunction

  task automatic model_reset();
    m_cnt = 0; m_up = 1; m_prd = 0; m_shd = 0; m_a = 0; m_b = 0;
  endtask

  task automatic model_step();
    int na, nb, ns, np, nc, nu;
    na = act_rule(m_a, int'(cmp_a), m_prd, m_cnt, m_up);
    nb = act_rule(m_b, int'(cmp_b), m_prd, m_cnt, m_up);
    ns = prd_wr ? int'(prd_val) : m_shd;
    np = (m_cnt == 0) ? m_shd : m_prd;
    if (sync_in && phs_en) begin
      nc = int'(phs_val); nu = int'(phs_dir);
    end else if (m_up == 1) begin
      if (m_cnt >= m_prd) begin
        if (m_prd == 0) begin nc = 0; nu = 1; end
        else begin nc = m_cnt - 1; nu = 0; end
      end else begin nc = m_cnt + 1; nu = 1; end
    end else begin
      if (m_cnt == 0) begin nc = (m_prd == 0) ? 0 : 1; nu = 1; end
      else begin nc = m_cnt - 1; nu = 0; end
    end
    m_a = na; m_b = nb; m_shd = ns; m_prd = np; m_cnt = nc; m_up = nu;
  endtask

  task automatic compare_all(string cnt_tag);
    int exp_sync;
    chk(cnt_tag, "cnt_o", int'(cnt_o), m_cnt);
    chk(cnt_tag, "dir_up_o", int'(dir_up_o), m_up);
    chk("R7", "pwm_a", int'(pwm_a), m_a);
    chk("R8", "pwm_b", int'(pwm_b), m_b);
    chk("R10", "zero_irq", int'(zero_irq), (m_cnt == 0) ? 1 : 0);
    exp_sync = sync_sel ? ((m_cnt == 0) ? 1 : 0) : int'(sync_in);
    chk("R6", "sync_out", int'(sync_out), exp_sync);
  endtask

  // one clock: model advances at the edge, outputs compared at the falling edge
  task automatic step(string cnt_tag);
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare_all(cnt_tag);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired, actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    int hold_a;
    string tag;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; prd_wr = 0; prd_val = '0; phs_en = 0; phs_dir = 0;
    phs_val = '0; sync_sel = 1; cmp_a = '0; cmp_b = '0; sync_in = 0;
    model_reset();
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "cnt_o", int'(cnt_o), 0);
    chk("R1", "dir_up_o", int'(dir_up_o), 1);
    chk("R1", "pwm_a", int'(pwm_a), 0);
    chk("R1", "pwm_b", int'(pwm_b), 0);
    rst_n = 1'b1;
    repeat (3) step("R1");

    // R2, R3: program a period of 8 and watch two triangles
    prd_wr = 1; prd_val = 6'd8; cmp_a = 6'd3; cmp_b = 6'd6;
    step("R3");
    prd_wr = 0;
    repeat (36) step("R2");

    // R3: write a new period mid-slope, old one stays until zero
    while (cnt_o != 6'd3) step("R2");
    prd_wr = 1; prd_val = 6'd12;
    step("R3");
    prd_wr = 0;
    repeat (40) step("R3");

    // R4: reload to half of period 12 with downward direction
    while (cnt_o != 6'd9 || dir_up_o != 1'b1) step("R2");
    phs_en = 1; phs_val = 6'd6; phs_dir = 0; sync_in = 1;
    step("R4");
    chk("R4", "cnt_o after sync", int'(cnt_o), 6);
    chk("R4", "dir_up_o after sync", int'(dir_up_o), 0);
    sync_in = 0;
    step("R4");
    chk("R4", "cnt_o step after load", int'(cnt_o), 5);

    // R4: reload above the period while counting up turns downward
    phs_val = 6'd20; phs_dir = 1; sync_in = 1;
    step("R4");
    sync_in = 0;
    step("R4");
    chk("R4", "cnt_o above period", int'(cnt_o), 19);

    // R5: master ignores sync
    repeat (30) step("R2");
    phs_en = 0; phs_val = 6'd2; sync_in = 1; sync_sel = 0;
    repeat (5) step("R5");
    sync_in = 0; sync_sel = 1;
    repeat (5) step("R5");

    // R9: compare 0 and compare above period hold the outputs
    cmp_a = '0; cmp_b = 6'd50;
    step("R9");
    hold_a = int'(pwm_a);
    repeat (30) step("R9");
    chk("R9", "pwm_a held with cmp 0", int'(pwm_a), hold_a);

    // random traffic
    cmp_a = 6'd4; cmp_b = 6'd9;
    for (int i = 0; i < 4000; i++) begin
      prd_wr  = ($urandom_range(0, 99) < 3);
      prd_val = 6'($urandom_range(1, 63));
      if ($urandom_range(0, 99) < 2) cmp_a = 6'($urandom_range(0, 63));
      if ($urandom_range(0, 99) < 2) cmp_b = 6'($urandom_range(0, 63));
      if ($urandom_range(0, 99) < 2) phs_en = 1'($urandom_range(0, 1));
      if ($urandom_range(0, 99) < 2) sync_sel = 1'($urandom_range(0, 1));
      phs_val = 6'($urandom_range(0, 63));
      phs_dir = 1'($urandom_range(0, 1));
      sync_in = ($urandom_range(0, 99) < 3);
      if (sync_in && phs_en) tag = "R4";
      else if (sync_in) tag = "R5";
      else tag = "R2";
      step(tag);
    end

    done = 1;
    summary();
    $finish;
  end
endmodule